// File: doc/BRIEF.md
# Paced Audio Sample FIFO

This block sits between a DMA-style producer and a downstream audio bus. The producer writes 32-bit audio subframe words into a circular buffer through a data port with a ready signal. The block releases these words on its own schedule and not on consumer demand. A fractional divider on the module clock produces a sample tick. On each tick the block hands one word per active channel to the output, all in the same cycle. This gives a sample period of N/(M+1) clocks on average, with no audio clock in the design.

Two request outputs tell the producer how full the buffer is. Each is a hysteresis comparator with its own pair of low and high thresholds. A normal request asks for more data. A panic request signals that the buffer is close to running dry. A small register port holds the control word, the threshold word and the divider word. The control word gives enable, channel count, flush and a one-shot reset. It also holds three sticky error flags: late data, underflow and overflow.

Top module: `paced_sample_fifo`

## Requirements
- R1: The divider word (address 2) holds N in bits [31:8] and M in bits [7:0]. While enabled, the accumulator starts from zero and adds M+1 each clock. After k accumulating cycles, floor(k*(M+1)/N) ticks have been produced. N = 0 produces no ticks. If M+1 > N, the divider saturates at one tick per cycle.
- R2: The channel count C is control bits [7:4]. Values above LANES act as LANES, and C = 0 never pops. A tick with enable bit 3 set and at least C words buffered pops C words. In the next cycle `smp_valid` is high for one cycle. Lane i carries the i-th oldest popped word, and lanes at or above C read zero.
- R3: A tick that finds the buffer empty sets the late-data flag (control bit 15). A tick that finds 1 to C-1 words sets the underflow flag (bit 2) and consumes nothing.
- R4: `wr_ready` is low exactly when DEPTH words are held. A write offered while `wr_ready` is low is dropped and sets the overflow flag (bit 1).
- R5: The flags at bits 15, 2 and 1 stay set until a control write has 1 at their position. Writing 0 leaves them unchanged. A set event in the same cycle as a clear wins.
- R6: A control write with bit 9 set empties the buffer in one cycle. It leaves the flags unchanged, except for the W1C bits of the same write. In that cycle, ticks and incoming words are ignored. Bit 9 reads back as 0.
- R7: A control write with bit 0 set overrides the rest of that write. It empties the buffer, clears the flags, enable, channel count and parity bit, and zeroes the accumulator. The threshold and divider words keep their values. Bit 0 reads back as 0.
- R8: The control word reads back as follows. Bit 14 is busy (enable and buffer not empty), bit 11 is full, bit 10 is empty, bit 8 is the stored parity-generate bit, bits [7:4] are the channel count and bit 3 is enable. All other non-flag bits read 0.
- R9: The threshold word (address 1) holds panic-high [29:24], panic-low [21:16], request-high [13:8] and request-low [5:0]. It reads back as written, with the other bits 0.
- R10: `dreq` rises in the cycle after the fill level is at or below request-low. It falls in the cycle after the level reaches request-high. Between the two it holds, and if both conditions are true the assert wins.
- R11: `panic` follows the same rule as R10, using panic-low and panic-high.
- R12: While `rst_n` is low, `smp_valid`, `dreq` and `panic` are 0, `wr_ready` is 1 and the control word reads 0x400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 thresholds, 2 divider |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Audio subframe word |
| wr_ready | output | 1 | Buffer has room |
| smp_valid | output | 1 | One-cycle pulse with a popped sample set |
| smp_data | output | LANES*DATA_W | Popped words, lane 0 oldest |
| dreq | output | 1 | Data request with hysteresis |
| panic | output | 1 | Urgent request with hysteresis |

## Verification
A sample tick and a refused producer write can fall in the same cycle when the buffer is full. The tick frees room, but `wr_ready` was computed from the full level at the start of that cycle. The bench holds `wr_valid` high against a full buffer while the divider runs. It then checks three things: the word is refused in the pop cycle, `wr_ready` is high in the cycle after the pop, and `wr_ready` is low again once the held word is taken. The overflow flag must also be set. A flush written while ticks are pending is a second such pair, judged by the flags kept across it.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int REG_W = 32;
  localparam int THR_W = 6;
  localparam int N_W   = 24;
  localparam int M_W   = 8;
  localparam int CH_W  = 4;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_THR  = 2'd1,
    REG_DIV  = 2'd2
  } psf_reg_e;

  // control word bit positions
  localparam int B_LATE  = 15;
  localparam int B_BUSY  = 14;
  localparam int B_FULL  = 11;
  localparam int B_EMPTY = 10;
  localparam int B_FLUSH = 9;
  localparam int B_PAR   = 8;
  localparam int B_CH_LO = 4;
  localparam int B_EN    = 3;
  localparam int B_UFL   = 2;
  localparam int B_OFL   = 1;
  localparam int B_SRST  = 0;

  typedef struct packed {
    logic [THR_W-1:0] lo;
    logic [THR_W-1:0] hi;
  } psf_thr_t;
endpackage

// File: rtl/psf_rate_tick.sv
module psf_rate_tick #(
  parameter int N_W = 24,
  parameter int M_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clr,
  input  logic [N_W-1:0] n_val,
  input  logic [M_W-1:0] m_val,
  output logic           tick
);
  localparam int ACC_W = N_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum, diff, n_ext;
  logic             tick_d;

  always_comb begin
    n_ext  = ACC_W'(n_val);
    sum    = acc_q + ACC_W'(m_val) + ACC_W'(1);
    diff   = sum - n_ext;
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (!run || clr || (n_val == '0)) begin
      acc_d = '0;
    end else if (sum >= n_ext) begin
      tick_d = 1'b1;
      acc_d  = (diff >= n_ext) ? '0 : diff;
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick  <= tick_d;
    end
  end

  // R1
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_val != '0) |=> (acc_q < ACC_W'($past(n_val))));
endmodule

// File: rtl/psf_store.sv
module psf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int LANES  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic [DATA_W-1:0]       push_data,
  input  logic [CNT_W-1:0]        pop_n,
  output logic [CNT_W-1:0]        level,
  output logic                    full,
  output logic                    empty,
  output logic [LANES*DATA_W-1:0] head
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_q] <= push_data;
    end
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) begin
        wr_d = wr_q + PTR_W'(1);
      end
      rd_d  = rd_q + PTR_W'(pop_n);
      cnt_d = cnt_q + CNT_W'(push) - pop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign level = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_head
    logic [PTR_W-1:0] idx;
    assign idx = rd_q + PTR_W'(i);
    assign head[i*DATA_W +: DATA_W] = mem_q[idx];
  end

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R4
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R2
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_n <= cnt_q);
endmodule

// File: rtl/psf_hyst.sv
module psf_hyst #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] lo,
  input  logic [LVL_W-1:0] hi,
  output logic             req
);
  logic req_d;

  always_comb begin
    if (level <= lo) begin
      req_d = 1'b1;
    end else if (level >= hi) begin
      req_d = 1'b0;
    end else begin
      req_d = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      req <= req_d;
    end
  end

  // R10 and R11
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(level) <= $past(lo)));
  // R10 and R11
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> ($past(level) >= $past(hi)));
endmodule

// File: rtl/paced_sample_fifo.sv
module paced_sample_fifo
  import psf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [1:0]              reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic                    wr_valid,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    wr_ready,
  output logic                    smp_valid,
  output logic [LANES*DATA_W-1:0] smp_data,
  output logic                    dreq,
  output logic                    panic
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // register state
  logic            en_q, en_d, par_q, par_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            late_q, late_d, uf_q, uf_d, of_q, of_d;
  psf_thr_t        dthr_q, pthr_q;
  logic [N_W-1:0]  n_q;
  logic [M_W-1:0]  m_q;

  // datapath signals
  logic                    ctrl_wr, soft_rst, flush, clr;
  logic                    tick, tick_ok, can_pop, pop_fire;
  logic                    late_set, uf_set, of_set, push;
  logic [CNT_W-1:0]        eff_ch, pop_n, level;
  logic                    full, empty;
  logic [LANES*DATA_W-1:0] head, lanes_d;
  logic                    smp_valid_q;
  logic [LANES*DATA_W-1:0] smp_data_q;

  assign ctrl_wr  = reg_we && (reg_addr == REG_CTRL);
  assign soft_rst = ctrl_wr && reg_wdata[B_SRST];
  assign flush    = ctrl_wr && reg_wdata[B_FLUSH];
  assign clr      = soft_rst || flush;

  assign eff_ch   = (int'(ch_q) > LANES) ? CNT_W'(LANES) : CNT_W'(ch_q);
  assign tick_ok  = tick && en_q && !clr && (eff_ch != '0);
  assign can_pop  = (level >= eff_ch);
  assign pop_fire = tick_ok && can_pop;
  assign pop_n    = pop_fire ? eff_ch : '0;
  assign late_set = tick_ok && (level == '0);
  assign uf_set   = tick_ok && (level != '0) && !can_pop;
  assign of_set   = wr_valid && full;
  assign push     = wr_valid && !full && !clr;
  assign wr_ready = !full;

  psf_rate_tick #(.N_W(N_W), .M_W(M_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_ni),
    .run   (en_q),
    .clr   (soft_rst),
    .n_val (n_q),
    .m_val (m_q),
    .tick  (tick)
  );

  psf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (clr),
    .push      (push),
    .push_data (wr_data),
    .pop_n     (pop_n),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .head      (head)
  );

  // hysteresis requests: index 0 normal request, index 1 panic
  logic [CMP_W-1:0] lo_v [2];
  logic [CMP_W-1:0] hi_v [2];
  logic [1:0]       req_v;
  assign lo_v[0] = CMP_W'(dthr_q.lo);
  assign hi_v[0] = CMP_W'(dthr_q.hi);
  assign lo_v[1] = CMP_W'(pthr_q.lo);
  assign hi_v[1] = CMP_W'(pthr_q.hi);

  for (genvar k = 0; k < 2; k++) begin : g_req
    psf_hyst #(.LVL_W(CMP_W)) u_hyst (
      .clk   (clk),
      .rst_n (rst_ni),
      .level (CMP_W'(level)),
      .lo    (lo_v[k]),
      .hi    (hi_v[k]),
      .req   (req_v[k])
    );
  end
  assign dreq  = req_v[0];
  assign panic = req_v[1];

  // output lanes: only the first eff_ch lanes carry data
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes_d[i*DATA_W +: DATA_W] =
      (CNT_W'(i) < eff_ch) ? head[i*DATA_W +: DATA_W] : '0;
  end

  // control next state
  always_comb begin
    en_d   = en_q;
    ch_d   = ch_q;
    par_d  = par_q;
    late_d = late_q;
    uf_d   = uf_q;
    of_d   = of_q;
    if (soft_rst) begin
      en_d   = 1'b0;
      ch_d   = '0;
      par_d  = 1'b0;
      late_d = 1'b0;
      uf_d   = 1'b0;
      of_d   = 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_d   = reg_wdata[B_EN];
        ch_d   = reg_wdata[B_CH_LO +: CH_W];
        par_d  = reg_wdata[B_PAR];
        late_d = late_q & ~reg_wdata[B_LATE];
        uf_d   = uf_q   & ~reg_wdata[B_UFL];
        of_d   = of_q   & ~reg_wdata[B_OFL];
      end
      late_d = late_d | late_set;
      uf_d   = uf_d   | uf_set;
      of_d   = of_d   | of_set;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ch_q   <= '0;
      par_q  <= 1'b0;
      late_q <= 1'b0;
      uf_q   <= 1'b0;
      of_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      ch_q   <= ch_d;
      par_q  <= par_d;
      late_q <= late_d;
      uf_q   <= uf_d;
      of_q   <= of_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dthr_q <= '0;
      pthr_q <= '0;
      n_q    <= '0;
      m_q    <= '0;
    end else begin
      if (reg_we && (reg_addr == REG_THR)) begin
        pthr_q.hi <= reg_wdata[29:24];
        pthr_q.lo <= reg_wdata[21:16];
        dthr_q.hi <= reg_wdata[13:8];
        dthr_q.lo <= reg_wdata[5:0];
      end
      if (reg_we && (reg_addr == REG_DIV)) begin
        n_q <= reg_wdata[31:8];
        m_q <= reg_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_valid_q <= 1'b0;
      smp_data_q  <= '0;
    end else begin
      smp_valid_q <= pop_fire;
      if (pop_fire) begin
        smp_data_q <= lanes_d;
      end
    end
  end
  assign smp_valid = smp_valid_q;
  assign smp_data  = smp_data_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: begin
        reg_rdata[B_LATE]             = late_q;
        reg_rdata[B_BUSY]             = en_q && !empty;
        reg_rdata[B_FULL]             = full;
        reg_rdata[B_EMPTY]            = empty;
        reg_rdata[B_PAR]              = par_q;
        reg_rdata[B_CH_LO +: CH_W]    = ch_q;
        reg_rdata[B_EN]               = en_q;
        reg_rdata[B_UFL]              = uf_q;
        reg_rdata[B_OFL]              = of_q;
      end
      REG_THR: begin
        reg_rdata[29:24] = pthr_q.hi;
        reg_rdata[21:16] = pthr_q.lo;
        reg_rdata[13:8]  = dthr_q.hi;
        reg_rdata[5:0]   = dthr_q.lo;
      end
      REG_DIV:  reg_rdata = {n_q, m_q};
      default:  reg_rdata = '0;
    endcase
  end

  // R3
  late_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && en_q && !clr && (eff_ch != '0) && (level == '0)) |=> late_q);
  // R4
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_valid && !wr_ready && !soft_rst) |=> of_q);
  // R2
  pop_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    smp_valid |-> $past(tick));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |=> (level == '0));
  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst |=> ((level == '0) && !en_q && !of_q && !late_q && !uf_q));
endmodule

// File: tb/tb_paced_sample_fifo.sv
module tb_paced_sample_fifo;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 32;
  localparam int LANES  = 8;
  // divider N, divider M, enabled window in cycles, expected pops
  localparam int NVEC = 7;
  localparam int VEC [NVEC][4] = '{
    '{4,    0,  41, 10},
    '{10,   2,  51, 15},
    '{7,    1,  36, 10},
    '{3,    2,  21, 20},
    '{1000, 99, 101, 10},
    '{5,    7,  31, 30},
    '{0,    5,  21, 0}
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    reg_we;
  logic [1:0]              reg_addr;
  logic [31:0]             reg_wdata;
  logic [31:0]             reg_rdata;
  logic                    wr_valid;
  logic [DATA_W-1:0]       wr_data;
  logic                    wr_ready;
  logic                    smp_valid;
  logic [LANES*DATA_W-1:0] smp_data;
  logic                    dreq;
  logic                    panic;

  int checks   = 0;
  int failures = 0;
  int push_seq = 0;
  int exp_next = 0;
  int pops     = 0;
  int mon_ch   = 1;
  logic [31:0] rd;

  paced_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .dreq      (dreq),
    .panic     (panic)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 32'hA000_0000 + push_seq;
      push_seq++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic flush_off();
    reg_write(2'd0, 32'h0000_0200);
    exp_next = push_seq;
  endtask

  task automatic wait_pop();
    do @(negedge clk); while (!smp_valid);
  endtask

  // R2: popped lanes carry the buffered words in order, unused lanes zero
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      pops++;
      for (int i = 0; i < LANES; i++) begin
        if (i < mon_ch) begin
          chk("R2", "lane word", smp_data[i*DATA_W +: DATA_W], 32'hA000_0000 + exp_next);
          exp_next++;
        end else begin
          chk("R2", "idle lane", smp_data[i*DATA_W +: DATA_W], 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "smp_valid in reset", {31'b0, smp_valid}, 32'h0);
    chk("R12", "dreq in reset", {31'b0, dreq}, 32'h0);
    chk("R12", "panic in reset", {31'b0, panic}, 32'h0);
    chk("R12", "wr_ready in reset", {31'b0, wr_ready}, 32'h1);
    chk("R12", "ctrl in reset", reg_rdata, 32'h0000_0400);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: divider pacing over a table of settings
    for (int v = 0; v < NVEC; v++) begin
      flush_off();
      fill(32);
      reg_write(2'd2, {VEC[v][0][23:0], VEC[v][1][7:0]});
      mon_ch = 1;
      pops   = 0;
      reg_write(2'd0, 32'h0000_0018);
      repeat (VEC[v][2] - 2) @(negedge clk);
      reg_write(2'd0, 32'h0000_0000);
      repeat (5) @(negedge clk);
      chk("R1", "ticks in window", pops, VEC[v][3]);
    end

    // R2 and R3: three channels, then a short buffer
    flush_off();
    reg_write(2'd0, 32'h0000_8006);
    fill(7);
    reg_write(2'd2, {24'd6, 8'd0});
    mon_ch = 3; pops = 0;
    reg_write(2'd0, 32'h0000_0038);
    repeat (30) @(negedge clk);
    chk("R2", "three-word pops", pops, 2);
    reg_read(2'd0, rd);
    chk("R3", "underflow busy ctrl", rd, 32'h0000_403C);
    // R6: flush while enabled keeps the underflow flag
    reg_write(2'd0, 32'h0000_0238);
    exp_next = push_seq;
    repeat (10) @(negedge clk);
    reg_read(2'd0, rd);
    chk("R6", "flags kept over flush", rd, 32'h0000_843C);
    chk("R3", "late flag on empty tick", {31'b0, rd[15]}, 32'h1);
    // R5: write-one clears only its bit, write-zero keeps
    reg_write(2'd0, 32'h0000_8030);
    reg_read(2'd0, rd);
    chk("R5", "late cleared", rd, 32'h0000_0434);
    reg_write(2'd0, 32'h0000_0000);
    reg_read(2'd0, rd);
    chk("R5", "zero write keeps flag", rd, 32'h0000_0404);
    reg_write(2'd0, 32'h0000_0004);

    // R2: channel count above LANES acts as LANES
    flush_off();
    fill(16);
    mon_ch = 8; pops = 0;
    reg_write(2'd0, 32'h0000_00F8);
    repeat (30) @(negedge clk);
    reg_write(2'd0, 32'h0000_0000);
    repeat (3) @(negedge clk);
    chk("R2", "clamped pops", pops, 2);

    // R4: overflow drops the word
    reg_write(2'd0, 32'h0000_8006);
    flush_off();
    fill(32);
    chk("R4", "wr_ready when full", {31'b0, wr_ready}, 32'h0);
    @(negedge clk); wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); wr_valid = 1'b0;
    reg_read(2'd0, rd);
    chk("R4", "overflow full ctrl", rd, 32'h0000_0802);
    reg_write(2'd2, {24'd1, 8'd0});
    mon_ch = 1; pops = 0;
    reg_write(2'd0, 32'h0000_0018);
    repeat (50) @(negedge clk);
    reg_write(2'd0, 32'h0000_0010);
    reg_read(2'd0, rd);
    chk("R4", "only stored words popped", pops, 32);
    chk("R4", "drained flags", rd, 32'h0000_8412);

    // R4: held write against full buffer in the pop cycle
    reg_write(2'd0, 32'h0000_8006);
    flush_off();
    fill(32);
    reg_write(2'd2, {24'd8, 8'd0});
    reg_write(2'd0, 32'h0000_0018);
    @(negedge clk); wr_valid = 1'b1; wr_data = 32'hCAFE_0000;
    wait_pop();
    chk("R4", "room after pop", {31'b0, wr_ready}, 32'h1);
    @(negedge clk);
    chk("R4", "refilled by held word", {31'b0, wr_ready}, 32'h0);
    wr_valid = 1'b0;
    reg_write(2'd0, 32'h0000_0010);
    reg_read(2'd0, rd);
    chk("R4", "overflow from held write", {31'b0, rd[1]}, 32'h1);

    // R9, R10, R11: thresholds and hysteresis
    reg_write(2'd0, 32'h0000_8006);
    flush_off();
    reg_write(2'd1, 32'hFF06_FA04 & 32'h3F3F_3F3F | 32'h0602_0A04);
    reg_write(2'd1, 32'h0602_0A04);
    reg_read(2'd1, rd);
    chk("R9", "threshold readback", rd, 32'h0602_0A04);
    repeat (2) @(negedge clk);
    chk("R10", "dreq at empty", {31'b0, dreq}, 32'h1);
    chk("R11", "panic at empty", {31'b0, panic}, 32'h1);
    for (int k = 1; k <= 10; k++) begin
      fill(1);
      @(negedge clk);
      if (k == 5) chk("R11", "panic held at 5", {31'b0, panic}, 32'h1);
      if (k == 6) chk("R11", "panic off at 6", {31'b0, panic}, 32'h0);
      if (k == 9) chk("R10", "dreq held at 9", {31'b0, dreq}, 32'h1);
      if (k == 10) chk("R10", "dreq off at 10", {31'b0, dreq}, 32'h0);
    end
    reg_write(2'd2, {24'd20, 8'd0});
    mon_ch = 1;
    reg_write(2'd0, 32'h0000_0018);
    for (int j = 1; j <= 6; j++) begin
      wait_pop();
      @(negedge clk);
      if (j == 5) chk("R10", "dreq held at 5", {31'b0, dreq}, 32'h0);
      if (j == 6) begin
        chk("R10", "dreq on at 4", {31'b0, dreq}, 32'h1);
        chk("R11", "panic held off at 4", {31'b0, panic}, 32'h0);
      end
    end

    // R7: one-shot reset dominates the write
    reg_write(2'd0, 32'h0000_0009);
    reg_read(2'd0, rd);
    chk("R7", "ctrl after soft reset", rd, 32'h0000_0400);
    reg_read(2'd1, rd);
    chk("R7", "thresholds kept", rd, 32'h0602_0A04);
    reg_read(2'd2, rd);
    chk("R7", "divider kept", rd, 32'h0000_1400);
    exp_next = push_seq;

    // R8: parity bit stored and read back
    reg_write(2'd0, 32'h0000_0100);
    reg_read(2'd0, rd);
    chk("R8", "parity readback", rd, 32'h0000_0500);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule